// File: doc/BRIEF.md
# Sequential Single-Precision Multiplier

The block multiplies two single-precision floating-point operands over a fixed number of clock cycles. A one-cycle start strobe hands it both operands. It takes the sign of the product from the two operand signs. It adds the two biased exponents and removes one bias, so the result stays in excess-127 form. The two 24-bit significands, each with its hidden leading one restored, are multiplied by a shift-and-add engine that uses one addition step per multiplier bit. No alignment happens before the multiply.

The 48-bit significand product lies in [1,4). When its top bit is set, it is shifted right once and the exponent goes up by one. The fraction is then truncated to 23 bits. An operand whose exponent field is zero is treated as zero. The packed result appears on a 32-bit output together with a one-cycle done pulse, and it stays there until the next result. Rounding, subnormal values, NaN, infinity and exponent range checks are left to the surrounding logic.

Top module: `fp_mul_seq`

## Requirements
- R1: While rst_ni is low, done_o is 0 and product_o is all zeros.
- R2: The word layout is sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. The product's bit 31 is the XOR of bit 31 of the two operands, for zero and non-zero results alike.
- R3: For non-zero operands, the result exponent field equals EA + EB - 127 when the significand product is below 2, where EA and EB are the operand exponent fields (bits 30:23).
- R4: When the 48-bit product of the two 24-bit significands (hidden one included) is 2 or more, the product is shifted right by one and the exponent field is EA + EB - 126. For example, 1.75 x 1.75 gives 0x40440000.
- R5: The result fraction is the 23 bits directly below the leading one of the significand product. The lower bits are discarded with no rounding, so 0x3FFFFFFF x 0x3FFFFFFF gives 0x407FFFFE.
- R6: If either operand has exponent field 0, the result has bits 30:0 all zero and bit 31 set as in R2.
- R7: A start_i seen high at a rising edge while the block is idle is accepted. done_o is then high for exactly one cycle, starting at the 25th rising edge after the accepting edge, and the result is valid on product_o in that cycle.
- R8: start_i is ignored from the accepting edge until done_o has been high. Such a strobe neither changes the pending result nor produces an extra done_o pulse.
- R9: product_o changes only in the cycle where done_o rises, and holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Strobe that launches a multiply when the block is idle |
| op_a_i | input | 32 | First operand, single precision |
| op_b_i | input | 32 | Second operand, single precision |
| product_o | output | 32 | Packed product, held until the next result |
| done_o | output | 1 | One-cycle pulse marking a new product |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent and a 23-bit fraction. This lets exact single-precision constants be checked, such as 1.5 x 2.0 = 3.0, the normalizing case 1.75 squared and the all-ones truncation case. At this width, the 25-cycle latency of the shift-and-add engine is also measured against the cycle counter. Signed zeros, an operand whose exponent field is zero and a start strobe issued mid-run are driven next to a run of pseudo-random operands, with exponents kept away from the range limits.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned DEF_EXP_W  = 8;
  localparam int unsigned DEF_FRAC_W = 23;

  function automatic int unsigned excess_of(input int unsigned exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int unsigned EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int unsigned WIDTH = 1 + EXP_W + FRAC_W
) (
  input  logic [WIDTH-1:0]  op_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W:0]   sig_o,
  output logic              zero_o
);
  assign sign_o = op_i[WIDTH-1];
  assign exp_o  = op_i[WIDTH-2 -: EXP_W];
  assign zero_o = (exp_o == '0);
  // hidden one restored only for non-zero exponent fields
  assign sig_o  = {~zero_o, op_i[FRAC_W-1:0]};
endmodule

// File: rtl/fpm_shift_add.sv
module fpm_shift_add #(
  parameter int unsigned SIG_W = 24,
  localparam int unsigned PROD_W = 2 * SIG_W,
  localparam int unsigned CNT_W  = $clog2(SIG_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SIG_W-1:0]  mcand_i,
  input  logic [SIG_W-1:0]  mplier_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [PROD_W-1:0] prod_o
);
  logic [PROD_W-1:0] mcand_q;
  logic [SIG_W-1:0]  mplier_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      prod_o   <= '0;
      busy_o   <= 1'b0;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load_i && !busy_o) begin
        mcand_q  <= {{SIG_W{1'b0}}, mcand_i};
        mplier_q <= mplier_i;
        prod_o   <= '0;
        cnt_q    <= CNT_W'(SIG_W);
        busy_o   <= 1'b1;
      end else if (busy_o) begin
        if (mplier_q[0]) prod_o <= prod_o + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          fin_o  <= 1'b1;
        end
      end
    end
  end

  assert_cnt_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0));
  assert_fin_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack #(
  parameter int unsigned EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int unsigned WIDTH  = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned PROD_W = 2 * SIG_W,
  localparam int unsigned XW     = EXP_W + 2
) (
  input  logic              sign_i,
  input  logic              zero_i,
  input  logic [EXP_W:0]    exp_sum_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [WIDTH-1:0]  res_o
);
  localparam logic [XW-1:0] BIAS = XW'(fpm_pkg::excess_of(EXP_W));

  logic              norm;
  logic [FRAC_W-1:0] frac;
  logic [XW-1:0]     exp_x;

  always_comb begin
    norm  = prod_i[PROD_W-1];
    frac  = norm ? prod_i[PROD_W-2 -: FRAC_W] : prod_i[PROD_W-3 -: FRAC_W];
    exp_x = {1'b0, exp_sum_i} + XW'(norm) - BIAS;
    if (zero_i) res_o = {sign_i, {(WIDTH-1){1'b0}}};
    else        res_o = {sign_i, exp_x[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fp_mul_seq.sv
module fp_mul_seq #(
  parameter int unsigned EXP_W  = fpm_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = fpm_pkg::DEF_FRAC_W,
  localparam int unsigned WIDTH  = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned PROD_W = 2 * SIG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  output logic [WIDTH-1:0] product_o,
  output logic             done_o
);
  logic              sa, sb, za, zb;
  logic [EXP_W-1:0]  ea, eb;
  logic [SIG_W-1:0]  ma, mb;
  logic              mul_busy, mul_fin, busy, accept;
  logic [PROD_W-1:0] prod;
  logic              sign_q, zero_q;
  logic [EXP_W:0]    exp_sum_q;
  logic [WIDTH-1:0]  packed_res;

  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .op_i(op_a_i), .sign_o(sa), .exp_o(ea), .sig_o(ma), .zero_o(za));
  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .op_i(op_b_i), .sign_o(sb), .exp_o(eb), .sig_o(mb), .zero_o(zb));

  assign busy   = mul_busy | mul_fin;
  assign accept = start_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_q    <= 1'b0;
      zero_q    <= 1'b0;
      exp_sum_q <= '0;
    end else if (accept) begin
      sign_q    <= sa ^ sb;
      zero_q    <= za | zb;
      exp_sum_q <= {1'b0, ea} + {1'b0, eb};
    end
  end

  fpm_shift_add #(.SIG_W(SIG_W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .mcand_i(ma), .mplier_i(mb),
    .busy_o(mul_busy), .fin_o(mul_fin), .prod_o(prod));

  fpm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign_i(sign_q), .zero_i(zero_q), .exp_sum_i(exp_sum_q),
    .prod_i(prod), .res_o(packed_res));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      product_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= mul_fin;
      if (mul_fin) product_o <= packed_res;
    end
  end

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mul_fin |=> $stable(product_o));
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(sign_q) && $stable(zero_q) && $stable(exp_sum_q)));
  assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_q) |-> (product_o[WIDTH-2:0] == '0));
  assert_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_fin && !zero_q) |-> (prod[PROD_W-1 -: 2] != 2'b00));
  assert_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (product_o[WIDTH-1] == sign_q));
endmodule

// File: tb/tb_fp_mul_seq.sv
module tb_fp_mul_seq;
  localparam int LAT = 26; // issue-cycle to done-cycle distance in bench counts (R7)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] product;
  logic        done;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_q[$];
  int          iss_q[$];
  string       req_q[$];
  logic [31:0] last_prod = '0;
  bit          have_last = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_mul_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .op_a_i(op_a), .op_b_i(op_b), .product_o(product), .done_o(done));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s;
    logic [47:0] p;
    logic [9:0]  e;
    s = a[31] ^ b[31];
    if (a[30:23] == 0 || b[30:23] == 0) return {s, 31'd0};
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = {2'b0, a[30:23]} + {2'b0, b[30:23]} - 10'd127;
    if (p[47]) return {s, 8'(e + 10'd1), p[46:24]};
    return {s, e[7:0], p[45:23]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input string req,
                       input bit intrude);
    @(negedge clk);
    exp_q.push_back(model(a, b));
    iss_q.push_back(cyc);
    req_q.push_back(req);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = '0; op_b = '0;
    if (intrude) begin
      repeat (5) @(negedge clk);
      op_a = 32'hC0A00000; op_b = 32'h00000000; start = 1'b1; // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8: unexpected done, actual %h expected none", product);
        end else begin
          logic [31:0] e;
          int          t;
          string       r;
          e = exp_q.pop_front(); t = iss_q.pop_front(); r = req_q.pop_front();
          check(r, product, e);
          check("R7 latency", 32'(cyc - t), 32'(LAT));
          last_prod = product; have_last = 1;
        end
      end else if (have_last) begin
        check("R9 hold", product, last_prod);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 product", product, 32'd0);
    rst_n = 1'b1;
    drive(32'h3FC00000, 32'h40000000, "R3 1.5*2", 0);
    check("R3 value", product, 32'h40400000);
    drive(32'h3FE00000, 32'h3FE00000, "R4 1.75^2", 0);
    check("R4 value", product, 32'h40440000);
    drive(32'h3F800000, 32'h3F800000, "R3 1*1", 0);
    drive(32'hBFC00000, 32'h40000000, "R2 neg", 0);
    check("R2 value", product, 32'hC0400000);
    drive(32'hBF800000, 32'hBF800000, "R2 neg*neg", 0);
    drive(32'h3FFFFFFF, 32'h3FFFFFFF, "R5 trunc", 0);
    check("R5 value", product, 32'h407FFFFE);
    drive(32'h00000000, 32'h40A00000, "R6 zero", 0);
    drive(32'h80000000, 32'h40400000, "R6 negzero", 0);
    check("R6 value", product, 32'h80000000);
    drive(32'hC0000000, 32'h007FFFFF, "R6 expzero", 0);
    drive(32'h40400000, 32'h40E00000, "R8 intrude", 1);
    check("R8 value", product, 32'h41A80000);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = {lfsr[31], 8'(100 + lfsr[7:0] % 50), lfsr[30:8]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = {lfsr[0], 8'(100 + lfsr[15:8] % 50), lfsr[24:2]};
      drive(a, b, "R5 random", 0);
    end
    repeat (5) @(negedge clk);
    check("R8 queue empty", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule